// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU with Carry Chain

This block is the arithmetic and logic unit of a small command-processor microcontroller. It takes a 5-bit function code and two 32-bit operands and returns a 32-bit result in the same cycle. One value is held between instructions: a 32-bit carry register. A wide add or subtract is split into two steps. The low-word operation loads the carry. The following high-word operation folds that stored carry into its own sum.

The carry register changes only when the caller asserts the carry write enable during an ADD or a SUB. This lets the instruction sequencer suppress carry updates, for example on repeated or cancelled instructions. The compare function does not produce status flags. It returns one of three fixed code values that firmware branches on.

An unrecognised function code gives a zero result. It also raises a registered error flag in the following cycle.

Top module: `mcu_alu`

## Requirements
- R1: ADD (code 0) returns the low 32 bits of srcA + srcB. With carryWe high, the carry register is loaded with bit 32 of the sum (0 or 1).
- R2: ADDHI (code 1) returns srcA + srcB + carry, modulo 2^32, and never changes the carry register.
- R3: SUB (code 2) returns srcA − srcB modulo 2^32. With carryWe high, the carry register becomes all ones when srcA < srcB (unsigned) and zero otherwise. SUBHI (code 3) returns srcA − srcB + carry and never changes the carry.
- R4: Reset clears the carry register to zero. The carry keeps its value unless carryWe is high with code 0 or 2.
- R5: AND (4), OR (5) and XOR (6) are bitwise. NOT (7) returns ~srcA for any srcB.
- R6: SHL (8) shifts srcA left, USHR (9) shifts it right logically, and ISHR (10) shifts it right arithmetically. All three shift by the full srcB. A shift amount of 32 or more gives 0 for SHL and USHR, and 32 copies of srcA[31] for ISHR.
- R7: ROT (11) rotates srcA left by srcB[4:0]. The upper bits of srcB are ignored.
- R8: MUL8 (12) returns srcA[7:0] × srcB[7:0] as an unsigned value, zero-extended to 32 bits.
- R9: MIN (13) and MAX (14) return the smaller and the larger operand, compared as unsigned values.
- R10: CMP (15) compares srcA with srcB as unsigned values. It returns 0x00 if srcA is greater, 0x2B if they are equal, and 0x1E if srcA is less.
- R11: MSB (16) returns the bit position of the highest set bit of srcB, and 0 when srcB is zero.
- R12: Codes 17 to 31 return a zero result and do not touch the carry. illegalOp is high in the cycle after such a code is applied at a clock edge, and low after any valid code. illegalOp is low out of reset.
- R13: The function codes are 5 bits wide: ADD 0, ADDHI 1, SUB 2, SUBHI 3, AND 4, OR 5, XOR 6, NOT 7, SHL 8, USHR 9, ISHR 10, ROT 11, MUL8 12, MIN 13, MAX 14, CMP 15, MSB 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| carryWe | input | 1 | Allows ADD or SUB to load the carry register at the clock edge |
| opcode | input | 5 | Function code |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| illegalOp | output | 1 | Registered flag for an unknown function code |

## Verification
The sweep targets the carry chain first. A design that stored only one borrow bit would make SUBHI add one instead of subtracting one. A design that updated the carry on ADDHI, or with the enable low, would corrupt later high-word results. Shift amounts of exactly 31, 32 and 33 are driven, so a design that shifts by only the low five bits gives a non-zero or unsigned-filled result where the requirement demands zero or a sign fill. The operands include values that are equal, values with the top bit set, and zero, so a signed compare, swapped compare codes, a truncated 8-bit product or an MSB that mishandles zero all give a wrong value.

// File: rtl/mcu_alu_pkg.sv
`timescale 1ns/1ps
package mcu_alu_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    FN_ADD   = 5'd0,
    FN_ADDHI = 5'd1,
    FN_SUB   = 5'd2,
    FN_SUBHI = 5'd3,
    FN_AND   = 5'd4,
    FN_OR    = 5'd5,
    FN_XOR   = 5'd6,
    FN_NOT   = 5'd7,
    FN_SHL   = 5'd8,
    FN_USHR  = 5'd9,
    FN_ISHR  = 5'd10,
    FN_ROT   = 5'd11,
    FN_MUL8  = 5'd12,
    FN_MIN   = 5'd13,
    FN_MAX   = 5'd14,
    FN_CMP   = 5'd15,
    FN_MSB   = 5'd16,
    FN_BAD   = 5'd31
  } aluFn_e;

  // strobes from control to datapath
  typedef struct packed {
    aluFn_e fn;
    logic   loadCarry;
    logic   illegal;
  } aluStrobe_t;

  localparam logic [7:0] CMP_GT = 8'h00;
  localparam logic [7:0] CMP_EQ = 8'h2B;
  localparam logic [7:0] CMP_LT = 8'h1E;
endpackage

// File: rtl/mcu_alu_ctrl.sv
`timescale 1ns/1ps
module mcu_alu_ctrl
  import mcu_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             carryWe,
  output aluStrobe_t       strobe
);
  logic   isBad;
  aluFn_e fnSel;

  always_comb begin
    isBad = (opcode > OPC_W'(FN_MSB));
    fnSel = isBad ? FN_BAD : aluFn_e'(opcode);
    strobe.fn        = fnSel;
    strobe.illegal   = isBad;
    strobe.loadCarry = carryWe && ((fnSel == FN_ADD) || (fnSel == FN_SUB));
  end
endmodule

// File: rtl/mcu_alu_dp.sv
`timescale 1ns/1ps
module mcu_alu_dp
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int PROD_W = 2 * MUL_W;

  logic [DATA_W-1:0] carryQ;
  logic [DATA_W:0]   addWide, subWide;
  logic [DATA_W-1:0] shlVal, ushrVal, ishrVal, rotVal, mulVal, cmpVal, msbVal;
  logic [2*DATA_W-1:0] rotWide;
  logic [PROD_W-1:0] prod;
  logic [SH_W-1:0]   shAmt, msbIdx;
  logic              shiftBig, borrow;

  assign addWide  = {1'b0, srcA} + {1'b0, srcB};
  assign subWide  = {1'b0, srcA} - {1'b0, srcB};
  assign borrow   = subWide[DATA_W];
  assign shAmt    = srcB[SH_W-1:0];
  assign shiftBig = |srcB[DATA_W-1:SH_W];

  always_comb begin
    shlVal  = shiftBig ? '0 : (srcA << shAmt);
    ushrVal = shiftBig ? '0 : (srcA >> shAmt);
    ishrVal = shiftBig ? {DATA_W{srcA[DATA_W-1]}} : DATA_W'($signed(srcA) >>> shAmt);
    rotWide = {srcA, srcA} << shAmt;
    rotVal  = rotWide[2*DATA_W-1:DATA_W];
    prod    = {{MUL_W{1'b0}}, srcA[MUL_W-1:0]} * {{MUL_W{1'b0}}, srcB[MUL_W-1:0]};
    mulVal  = DATA_W'(prod);
    if (srcA > srcB)       cmpVal = DATA_W'(CMP_GT);
    else if (srcA == srcB) cmpVal = DATA_W'(CMP_EQ);
    else                   cmpVal = DATA_W'(CMP_LT);
    msbIdx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (srcB[i]) msbIdx = SH_W'(i);
    end
    msbVal = DATA_W'(msbIdx);
  end

  always_comb begin
    unique case (strobe.fn)
      FN_ADD:   result = addWide[DATA_W-1:0];
      FN_ADDHI: result = srcA + srcB + carryQ;
      FN_SUB:   result = subWide[DATA_W-1:0];
      FN_SUBHI: result = srcA - srcB + carryQ;
      FN_AND:   result = srcA & srcB;
      FN_OR:    result = srcA | srcB;
      FN_XOR:   result = srcA ^ srcB;
      FN_NOT:   result = ~srcA;
      FN_SHL:   result = shlVal;
      FN_USHR:  result = ushrVal;
      FN_ISHR:  result = ishrVal;
      FN_ROT:   result = rotVal;
      FN_MUL8:  result = mulVal;
      FN_MIN:   result = (srcA < srcB) ? srcA : srcB;
      FN_MAX:   result = (srcA < srcB) ? srcB : srcA;
      FN_CMP:   result = cmpVal;
      FN_MSB:   result = msbVal;
      default:  result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ    <= '0;
      illegalOp <= 1'b0;
    end else begin
      illegalOp <= strobe.illegal;
      if (strobe.loadCarry) begin
        carryQ <= (strobe.fn == FN_SUB) ? {DATA_W{borrow}}
                                        : DATA_W'(addWide[DATA_W]);
      end
    end
  end

  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCarry |=> $stable(carryQ));
  assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCarry && strobe.fn == FN_SUB) |=> (carryQ == '0 || carryQ == '1));
  assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCarry && strobe.fn == FN_ADD) |=> (carryQ <= DATA_W'(1)));
  assert_illegal_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |=> illegalOp);
  assert_illegal_clr_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.illegal |=> !illegalOp);
  assert_illegal_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |-> (result == '0));
  assert_cmp_codes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fn == FN_CMP) |-> (result == DATA_W'(CMP_GT) || result == DATA_W'(CMP_EQ)
                               || result == DATA_W'(CMP_LT)));
  assert_mul_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fn == FN_MUL8) |-> (result[DATA_W-1:PROD_W] == '0));
  assert_msb_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fn == FN_MSB) |-> (result < DATA_W'(DATA_W)));
endmodule

// File: rtl/mcu_alu.sv
`timescale 1ns/1ps
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              carryWe,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);
  aluStrobe_t strobe;

  mcu_alu_ctrl ctrl_i (
    .opcode  (opcode),
    .carryWe (carryWe),
    .strobe  (strobe)
  );

  mcu_alu_dp #(.DATA_W(DATA_W), .MUL_W(MUL_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcA      (srcA),
    .srcB      (srcB),
    .result    (result),
    .illegalOp (illegalOp)
  );
endmodule

// File: tb/mcu_alu_tb_top.sv
`timescale 1ns/1ps
module mcu_alu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        carryWe = 1'b0;
  logic [4:0]  opcode = 5'd0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [31:0] result;
  logic        illegalOp;

  int checkCount = 0;
  int errCount = 0;
  logic [31:0] mCarry = '0;
  logic        expIll = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mcu_alu dut_i (
    .clk(clk), .rstN(rstN), .carryWe(carryWe), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .result(result), .illegalOp(illegalOp)
  );

  function automatic string tagOf(input logic [4:0] op);
    case (op)
      5'd0: return "R1";
      5'd1: return "R2";
      5'd2, 5'd3: return "R3";
      5'd4, 5'd5, 5'd6, 5'd7: return "R5";
      5'd8, 5'd9, 5'd10: return "R6";
      5'd11: return "R7";
      5'd12: return "R8";
      5'd13, 5'd14: return "R9";
      5'd15: return "R10";
      5'd16: return "R11";
      default: return "R12";
    endcase
  endfunction

  // reference model, built from the requirements (codes per R13)
  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] c);
    logic [63:0] w;
    int idx;
    case (op)
      5'd0:  return a + b;
      5'd1:  return a + b + c;
      5'd2:  return a - b;
      5'd3:  return a - b + c;
      5'd4:  return a & b;
      5'd5:  return a | b;
      5'd6:  return a ^ b;
      5'd7:  return ~a;
      5'd8:  return (b >= 32) ? 32'd0 : (a << b[4:0]);
      5'd9:  return (b >= 32) ? 32'd0 : (a >> b[4:0]);
      5'd10: begin
        w = {{32{a[31]}}, a};
        return (b >= 32) ? {32{a[31]}} : w[31 + b[4:0] -: 32];
      end
      5'd11: begin
        w = {a, a};
        return w[63 - b[4:0] -: 32];
      end
      5'd12: return 32'(a[7:0]) * 32'(b[7:0]);
      5'd13: return (a < b) ? a : b;
      5'd14: return (a > b) ? a : b;
      5'd15: return (a > b) ? 32'h00 : ((a == b) ? 32'h2B : 32'h1E);
      5'd16: begin
        idx = 0;
        for (int i = 0; i < 32; i++) if (b[i]) idx = i;
        return 32'(idx);
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag,
                       input string what);
    checkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic we, input string tag);
    @(negedge clk);
    opcode = op; srcA = a; srcB = b; carryWe = we;
    #1;
    check(result, model(op, a, b, mCarry), tag, $sformatf("op=%0d a=%h b=%h (R13)", op, a, b));
    check(32'(illegalOp), 32'(expIll), "R12", "illegalOp flag");
    @(posedge clk);
    if (we && op == 5'd0) mCarry = 32'((33'(a) + 33'(b)) >> 32);
    if (we && op == 5'd2) mCarry = (a < b) ? 32'hFFFF_FFFF : 32'h0;
    expIll = (op > 5'd16);
  endtask

  logic [31:0] vals [14] = '{32'h0, 32'h1, 32'h2, 32'h7, 32'd31, 32'd32, 32'd33,
                             32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
                             32'h1234_5678, 32'h0000_00FF, 32'hDEAD_BEEF, 32'h0000_0100};

  initial begin
    #(8 * 200000);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checkCount, errCount);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // reset state
    check(32'(illegalOp), 32'h0, "R12", "illegalOp in reset");
    @(negedge clk);
    rstN = 1'b1;
    runOp(5'd1, 32'h0, 32'h0, 1'b1, "R4");

    // directed carry chain
    runOp(5'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, "R1");
    runOp(5'd1, 32'h0, 32'h0, 1'b1, "R2");   // returns carry 1, carry stays
    runOp(5'd2, 32'h0, 32'h1, 1'b0, "R4");   // enable low: carry kept
    runOp(5'd1, 32'h0, 32'h0, 1'b0, "R4");
    runOp(5'd2, 32'h0, 32'h1, 1'b1, "R3");   // borrow -> all ones
    runOp(5'd3, 32'h5, 32'h2, 1'b1, "R3");   // 5-2-1 = 2
    runOp(5'd1, 32'h5, 32'h0, 1'b1, "R3");   // 5+ones = 4
    runOp(5'd20, 32'h3, 32'h4, 1'b1, "R12"); // illegal, carry untouched
    runOp(5'd1, 32'h0, 32'h0, 1'b0, "R12");
    runOp(5'd7, 32'h0F0F_0000, 32'h1234_5678, 1'b0, "R5");
    runOp(5'd11, 32'h8000_0001, 32'hFFFF_FFE1, 1'b0, "R7");

    // near-exhaustive sweep over valid codes and operand corners
    n = 0;
    for (int op = 0; op <= 16; op++) begin
      for (int i = 0; i < 14; i++) begin
        for (int j = 0; j < 14; j++) begin
          runOp(5'(op), vals[i], vals[j], (n % 3) != 0, tagOf(5'(op)));
          n++;
        end
      end
    end
    // unknown codes, interleaved with a valid one to see the flag drop
    for (int op = 17; op < 32; op++) begin
      runOp(5'(op), vals[op % 14], vals[(op + 3) % 14], 1'b1, "R12");
      runOp(5'd1, 32'h0, 32'h0, 1'b0, "R12");
    end
    @(negedge clk);
    #1;
    check(32'(illegalOp), 32'h0, "R12", "flag after valid code");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checkCount, errCount);
    $finish;
  end
endmodule